// File: doc/BRIEF.md
# Stop-Mode Wake-Up Recovery Controller

This block decides when a device parked in stop mode resumes. It holds an 8-bit recovery control register. The register selects a wake-up source, the level that counts as active and the length of the recovery. It also enables a divide-by-16 clock prescaler and carries a flag, set by hardware, that separates a warm start from a cold one. The wake-up source is either a single port pin or the NOR of a group of port pins. Each pin passes through a two-flop synchroniser before selection.

Recovery takes one of two paths. On the fast path, the chosen source must stay active for a qualification run of consecutive synchronised cycles, and then the wake request pulses for a single cycle. On the slow path, the first active cycle starts a long down-counter, and the wake request (the reset request) stays asserted until the counter expires. In both cases the block then returns to the run state.

Top module: `stop_wake_ctl`

## Requirements
- R1: Power-on reset (`por`, asynchronous) sets the register to 8'h20: prescaler off, source code 000, slow/fast bit 5 = 1, level bit 6 = 0, warm flag bit 7 = 0. It also puts the block in the run state with `wake_req` low.
- R2: A write (`wr_en`) loads bits 6:2 and bit 0 from `wr_data`. Bit 1 always reads 0. A write never changes bit 7.
- R3: `prescale_en` equals register bit 0, and changes in the cycle after the write.
- R4: `stop_req` in the run state enters stop (`stop_active` high) and sets bit 7 to 1 (warm).
- R5: `wdt_rst` or `ext_rst` leaves stop or recovery, clears bit 7 and keeps bits 6:0 unchanged.
- R6: Source code in bits 4:2: 010 = `sgl_pins[0]`, 011 = `sgl_pins[1]`, 100 = `sgl_pins[2]`, 101 = `grp_pins[7]`, 110 = NOR of `grp_pins[3:0]`, 111 = NOR of `grp_pins[7:0]`. Codes 000 and 001 never wake.
- R7: With bit 6 = 1 the source is active when high; with bit 6 = 0 it is active when low. For the NOR codes the level is applied to the NOR result.
- R8: With bit 5 = 1, the source must be active for FAST_QUAL consecutive synchronised cycles. `wake_req` then rises FAST_QUAL+2 clock edges after the pin change, lasts one cycle, and the block returns to run. A shorter active run gives no wake.
- R9: With bit 5 = 0, `wake_req` rises 3 edges after the pin change, stays high for DELAY_CYC cycles and then falls as `stop_active` stays low.
- R10: Outside stop, no pin activity raises `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, asynchronous, active high |
| wdt_rst | input | 1 | Watchdog reset, synchronous, active high |
| ext_rst | input | 1 | External reset, synchronous, active high |
| stop_req | input | 1 | Stop-entry strobe |
| grp_pins | input | 8 | Port group pins, bit i = pin i of the group |
| sgl_pins | input | 3 | Three individual wake pins |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| prescale_en | output | 1 | Divide-by-16 prescaler enable |
| stop_active | output | 1 | High while in stop |
| wake_req | output | 1 | Wake / reset request |

## Verification
The bench builds the block with DELAY_CYC = 20 and FAST_QUAL = 5. With these values every slow recovery is short enough to be timed edge by edge, and the qualification window is short enough to be probed one cycle below and one cycle at its length. With that configuration the bench sweeps all eight source codes, both levels and both recovery paths. Each sweep point is tried against single-pin toggles and all-zero and all-one pin patterns, and every outcome is compared against an arithmetic model of the selection rule.

// File: rtl/stop_wake_ctl.sv
`timescale 1ns/1ps
module stop_wake_ctl #(
  parameter int DELAY_CYC = 50000,
  parameter int FAST_QUAL = 5
) (
  input  logic       clk,
  input  logic       por,
  input  logic       wdt_rst,
  input  logic       ext_rst,
  input  logic       stop_req,
  input  logic [7:0] grp_pins,
  input  logic [2:0] sgl_pins,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       prescale_en,
  output logic       stop_active,
  output logic       wake_req
);
  localparam int MAXC = (DELAY_CYC > FAST_QUAL) ? DELAY_CYC : FAST_QUAL;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_HOLD} st_t;

  logic [10:0]   sync1, sync2;
  logic          prediv, fast, lvl_hi, warm;
  logic [2:0]    sel;
  st_t           st;
  logic [CW-1:0] cnt;
  logic          src, hit, soft_rst;

  assign soft_rst = wdt_rst | ext_rst;

  always_ff @(posedge clk or posedge por)
    if (por) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {sgl_pins, grp_pins};
      sync2 <= sync1;
    end

  always_ff @(posedge clk or posedge por)
    if (por) begin
      prediv <= 1'b0;
      sel    <= 3'd0;
      fast   <= 1'b1;
      lvl_hi <= 1'b0;
    end else if (wr_en) begin
      prediv <= wr_data[0];
      sel    <= wr_data[4:2];
      fast   <= wr_data[5];
      lvl_hi <= wr_data[6];
    end

  always_ff @(posedge clk or posedge por)
    if (por)                           warm <= 1'b0;
    else if (soft_rst)                 warm <= 1'b0;
    else if (st == S_RUN && stop_req)  warm <= 1'b1;

  always_comb
    case (sel)
      3'd2:    src = sync2[8];
      3'd3:    src = sync2[9];
      3'd4:    src = sync2[10];
      3'd5:    src = sync2[7];
      3'd6:    src = ~|sync2[3:0];
      3'd7:    src = ~|sync2[7:0];
      default: src = 1'b0;
    endcase

  assign hit = (sel >= 3'd2) && (src == lvl_hi);

  always_ff @(posedge clk or posedge por)
    if (por) begin
      st  <= S_RUN;
      cnt <= '0;
    end else if (soft_rst) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          cnt <= '0;
          if (stop_req) st <= S_STOP;
        end
        S_STOP: begin
          if (!hit) cnt <= '0;
          else if (!fast) begin
            st  <= S_HOLD;
            cnt <= CW'(DELAY_CYC);
          end else if (cnt == CW'(FAST_QUAL - 1)) begin
            st  <= S_HOLD;
            cnt <= CW'(1);
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (cnt <= CW'(1)) begin
            st  <= S_RUN;
            cnt <= '0;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          st  <= S_RUN;
          cnt <= '0;
        end
      endcase
    end

  assign rd_data     = {warm, lvl_hi, fast, sel, 1'b0, prediv};
  assign prescale_en = prediv;
  assign stop_active = (st == S_STOP);
  assign wake_req    = (st == S_HOLD);
endmodule

// File: rtl/stop_wake_ctl_chk.sv
`timescale 1ns/1ps
module stop_wake_ctl_chk (
  input logic       clk,
  input logic       por,
  input logic       wdt_rst,
  input logic       ext_rst,
  input logic       stop_req,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       prescale_en,
  input logic       stop_active,
  input logic       wake_req
);
  p_warm_write_ignored_r2: assert property (@(posedge clk) disable iff (por)
    (wr_en && !stop_req && !rd_data[7]) |=> !rd_data[7]);

  p_prescale_follows_r3: assert property (@(posedge clk) disable iff (por)
    (wr_en && !wdt_rst && !ext_rst) |=> prescale_en == $past(wr_data[0]));

  p_stop_entry_r4: assert property (@(posedge clk) disable iff (por)
    (stop_req && !stop_active && !wake_req && !wdt_rst && !ext_rst) |=> (stop_active && rd_data[7]));

  p_soft_reset_r5: assert property (@(posedge clk) disable iff (por)
    (wdt_rst || ext_rst) |=> (!rd_data[7] && !stop_active && !wake_req));

  p_wake_from_stop_r10: assert property (@(posedge clk) disable iff (por)
    $rose(wake_req) |-> $past(stop_active));

  p_stop_exclusive_r9: assert property (@(posedge clk) disable iff (por)
    !(wake_req && stop_active));

  p_stop_leaves_via_wake_r8: assert property (@(posedge clk) disable iff (por)
    (stop_active && !wdt_rst && !ext_rst) |=> (stop_active || wake_req));
endmodule

bind stop_wake_ctl stop_wake_ctl_chk u_chk (.*);

// File: tb/stop_wake_ctl_test.sv
`timescale 1ns/1ps
module stop_wake_ctl_test;
  localparam int DLY  = 20;
  localparam int QUAL = 5;

  logic clk = 1'b0;
  logic por = 1'b1, wdt_rst = 1'b0, ext_rst = 1'b0, stop_req = 1'b0;
  logic [10:0] pins = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic prescale_en, stop_active, wake_req;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  stop_wake_ctl #(.DELAY_CYC(DLY), .FAST_QUAL(QUAL)) uut (
    .clk(clk), .por(por), .wdt_rst(wdt_rst), .ext_rst(ext_rst), .stop_req(stop_req),
    .grp_pins(pins[7:0]), .sgl_pins(pins[10:8]), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .prescale_en(prescale_en), .stop_active(stop_active), .wake_req(wake_req));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
  endtask

  function automatic logic exp_hit(input logic [2:0] code, input logic pol, input logic [10:0] p);
    logic s;
    case (code)
      3'd2: s = p[8];
      3'd3: s = p[9];
      3'd4: s = p[10];
      3'd5: s = p[7];
      3'd6: s = (p[3:0] == 4'h0);
      3'd7: s = (p[7:0] == 8'h00);
      default: return 1'b0;
    endcase
    return s == pol;
  endfunction

  // watch pin response: first edge index with wake_req high, and its width
  task automatic watch(input int len, output int first, output int wid);
    first = -1; wid = 0;
    for (int k = 1; k <= len; k++) begin
      @(posedge clk); #1;
      if (wake_req) begin
        if (first < 0) first = k;
        wid++;
      end
    end
  endtask

  task automatic trial(input logic [2:0] code, input logic pol, input logic fst, input logic [10:0] stim);
    logic [10:0] base;
    logic [7:0] cfg;
    int first, wid;
    base = (code >= 3'd6) ? (pol ? '1 : '0) : (pol ? '0 : '1);
    cfg = {1'b0, pol, fst, code, 2'b00};
    @(negedge clk); pins = base;
    wr(cfg);
    repeat (4) @(negedge clk);
    pulse_stop();
    chk("R4 stop_active", stop_active, 1);
    chk("R4 warm", rd_data[7], 1);
    pins = stim;
    watch(DLY + QUAL + 8, first, wid);
    if (exp_hit(code, pol, stim)) begin
      chk(fst ? "R8 latency" : "R9 latency", first, fst ? QUAL + 2 : 3);
      chk(fst ? "R8 width" : "R9 width", wid, fst ? 1 : DLY);
      chk("R9 back to run", stop_active, 0);
    end else begin
      chk("R6/R7 no wake", first, -1);
      chk("R6 still stopped", stop_active, 1);
      pulse_ext();
      #1;
      chk("R5 ext leaves stop", stop_active, 0);
      chk("R5 fields kept", rd_data, cfg);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int first, wid;
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    chk("R1 reset value", rd_data, 8'h20);
    chk("R1 prescale", prescale_en, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 stop_active", stop_active, 0);

    wr(8'hFF);
    chk("R2 write mask", rd_data, 8'h7D);
    chk("R3 prescale on", prescale_en, 1);
    wr(8'hFE);
    chk("R2 write mask", rd_data, 8'h7C);
    chk("R3 prescale off", prescale_en, 0);

    // R10: activity in run state
    wr(8'h68);
    @(negedge clk); pins = '0;
    repeat (4) @(negedge clk);
    pins[8] = 1'b1;
    watch(15, first, wid);
    chk("R10 no wake in run", first, -1);
    chk("R10 stays run", stop_active, 0);

    // R5: watchdog reset during stop
    @(negedge clk); pins = '0;
    repeat (4) @(negedge clk);
    pulse_stop();
    chk("R4 stop entry", stop_active, 1);
    @(negedge clk); wdt_rst = 1'b1;
    @(negedge clk); wdt_rst = 1'b0;
    chk("R5 wdt leaves stop", stop_active, 0);
    chk("R5 wdt clears warm", rd_data, 8'h68);

    // R8: qualification boundary, 4 active cycles then 5
    pulse_stop();
    @(negedge clk); pins[8] = 1'b1;
    repeat (QUAL - 1) @(negedge clk);
    pins[8] = 1'b0;
    watch(15, first, wid);
    chk("R8 short run ignored", first, -1);
    chk("R8 still stopped", stop_active, 1);
    @(negedge clk); pins[8] = 1'b1;
    repeat (QUAL) @(negedge clk);
    pins[8] = 1'b0;
    watch(15, first, wid);
    chk("R8 full run wakes", first > 0, 1);
    chk("R8 one cycle", wid, 1);

    // full sweep
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 8; c++)
        for (int p = 0; p < 2; p++) begin
          logic [10:0] b;
          b = (c >= 6) ? (p != 0 ? '1 : '0) : (p != 0 ? '0 : '1);
          for (int i = 0; i < 11; i++)
            trial(3'(c), p[0], f[0], b ^ (11'd1 << i));
          trial(3'(c), p[0], f[0], '0);
          trial(3'(c), p[0], f[0], '1);
        end

    // R1: power-on reset after use
    wr(8'h5D);
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    @(negedge clk);
    chk("R1 por restores", rd_data, 8'h20);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule